// File: doc/BRIEF.md
# Half-Integer Clock Divider

This block derives a slower clock from a fast input clock. The ratio comes from a small configuration code, and the supported ratios are every integer from 2 to 16 plus the half-integer values 1.5, 2.5 and so on up to 7.5. The block tracks time in input half-periods and updates state on both edges of the input clock. For this reason a half-integer ratio can still give a periodic output. Its transitions land on rising and falling input edges in turn.

An optional pre-halving stage doubles the effective ratio. Configuration is taken only while the synchronous reset is held. After release, the first output rising edge falls on the first rising input edge. This fixes the output's phase relative to the reference. The output stays low throughout reset, so nothing leaves the block before the configuration is stable.

Top module: `halfstep_clkdiv`

## Requirements
- R1: For an even ratio code C from 4 to 32 (ratio C/2), the output period lasts exactly C input half-periods. The output is high for the first C/2 half-periods of each period, which gives a 50% duty cycle. For odd ratios, the falling output transition lands on a falling input edge.
- R2: For an odd ratio code C from 3 to 15 (ratio C/2), the output period lasts exactly C input half-periods. The output is high for the first (C+1)/2 of them, and successive output rising edges alternate between rising and falling input edges.
- R3: The first rising input edge after reset release starts the output high. That half-period is index 0 of the repeating pattern.
- R4: When the pre-divide enable is 1 during reset, the period is 2·P input half-periods instead of P, where P is the period the code alone selects. The output is high for the first P of them.
- R5: Codes outside the supported set (0, 1, 2, odd values above 15, values above 32) behave exactly like code 4, a ratio of 2.
- R6: Changes to the ratio code or the pre-divide enable while reset is low have no effect on the output until the next reset.
- R7: The output is low from the first rising input edge at which reset is sampled high until the first rising edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Reference clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset, sampled on the rising edge |
| ratio_code | input | 6 | Twice the desired ratio (3..32), captured during reset |
| prediv_en | input | 1 | 1 halves the reference before the main divider, captured during reset |
| clk_out | output | 1 | Divided clock |

## Verification
The bench builds the block with the package defaults: a 6-bit code, a largest code of 32 and a pre-divide shift of 1. The half-period counter is therefore 7 bits wide and the longest period is 64 half-periods. These values put both ends of the code range within reach: the shortest period of 3 half-periods, where wrap and the alternation of edges occur on every output cycle, and the longest period of 64 half-periods, which uses the counter's top bit. With these settings each captured pattern can also be compared, half-period by half-period, against a pattern the bench computes over three full output periods.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;
  localparam int CODE_W    = 6;
  localparam int MAX_CODE  = 32;
  localparam int PRE_SHIFT = 1;
  localparam int CNT_W     = $clog2((MAX_CODE << PRE_SHIFT) + 1);

  localparam logic [CODE_W-1:0] ODD_LO   = CODE_W'(3);
  localparam logic [CODE_W-1:0] ODD_HI   = CODE_W'(15);
  localparam logic [CODE_W-1:0] EVEN_LO  = CODE_W'(4);
  localparam logic [CODE_W-1:0] EVEN_HI  = CODE_W'(MAX_CODE);
  localparam logic [CODE_W-1:0] FALLBACK = CODE_W'(4);

  typedef logic [CNT_W-1:0] half_t;

  typedef struct packed {
    half_t period;  // half-periods per output period
    half_t high;    // leading half-periods spent high
  } span_t;

  function automatic logic code_legal(input logic [CODE_W-1:0] c);
    if (c[0]) return (c >= ODD_LO) && (c <= ODD_HI);
    return (c >= EVEN_LO) && (c <= EVEN_HI);
  endfunction

  function automatic half_t period_of(input logic [CODE_W-1:0] c, input logic pre);
    half_t base;
    base = code_legal(c) ? half_t'(c) : half_t'(FALLBACK);
    return pre ? half_t'(base << PRE_SHIFT) : base;
  endfunction

  function automatic half_t high_of(input half_t n);
    logic [CNT_W:0] s;
    s = {1'b0, n} + (CNT_W+1)'(1);
    return s[CNT_W:1];
  endfunction

  function automatic half_t step_mod(input half_t h, input half_t n, input logic two);
    logic [CNT_W:0] s;
    s = {1'b0, h} + (two ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
    if (s >= {1'b0, n}) return half_t'(s - {1'b0, n});
    return half_t'(s);
  endfunction
endpackage

// File: rtl/hdiv_cfg.sv
module hdiv_cfg
  import hdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic              pre,
  output half_t             load_period,
  output span_t             span_q
);
  assign load_period = period_of(code, pre);

  always_ff @(posedge clk) begin
    if (rst) begin
      span_q.period <= load_period;
      span_q.high   <= high_of(load_period);
    end
  end

  // Captured span is always legal and splits the period as evenly as possible
  p_span_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (span_q.period >= half_t'(3)) && (span_q.period <= half_t'(MAX_CODE << PRE_SHIFT)));
  p_span_split_r2: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, span_q.high} << 1) >= {1'b0, span_q.period} &&
    ({1'b0, span_q.high} << 1) <= {1'b0, span_q.period} + (CNT_W+1)'(1));
endmodule

// File: rtl/hdiv_rise.sv
module hdiv_rise
  import hdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  half_t load_period,
  input  span_t span,
  input  logic  fq,
  output logic  run,
  output half_t hp,
  output logic  rq
);
  half_t nxt;
  assign nxt = step_mod(hp, span.period, 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      hp  <= load_period - half_t'(2);  // first step lands on index 0
      rq  <= 1'b0;
    end else begin
      run <= 1'b1;
      hp  <= nxt;
      rq  <= (nxt < span.high) ^ fq;
    end
  end

  p_rise_range_r1: assert property (@(posedge clk) disable iff (rst)
    run |-> (hp < span.period));
  p_align_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (hp == half_t'(0)));
endmodule

// File: rtl/hdiv_fall.sv
module hdiv_fall
  import hdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  span_t span,
  input  logic  rq,
  output half_t hn,
  output logic  fq
);
  half_t nxt;
  assign nxt = step_mod(hn, span.period, 1'b1);

  always_ff @(negedge clk) begin
    if (!run) begin
      hn <= span.period - half_t'(1);  // first step lands on index 1
      fq <= 1'b0;
    end else begin
      hn <= nxt;
      fq <= (nxt < span.high) ^ rq;
    end
  end

  p_fall_range_r2: assert property (@(negedge clk) disable iff (rst)
    run |-> (hn < span.period));
endmodule

// File: rtl/halfstep_clkdiv.sv
module halfstep_clkdiv
  import hdiv_pkg::*;
(
  input  logic              clk_in,
  input  logic              rst,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              prediv_en,
  output logic              clk_out
);
  half_t load_period;
  span_t span;
  logic  run, rq, fq;
  half_t hp, hn;

  hdiv_cfg u_cfg (
    .clk(clk_in), .rst(rst), .code(ratio_code), .pre(prediv_en),
    .load_period(load_period), .span_q(span)
  );

  hdiv_rise u_rise (
    .clk(clk_in), .rst(rst), .load_period(load_period), .span(span),
    .fq(fq), .run(run), .hp(hp), .rq(rq)
  );

  hdiv_fall u_fall (
    .clk(clk_in), .rst(rst), .run(run), .span(span),
    .rq(rq), .hn(hn), .fq(fq)
  );

  assign clk_out = (rq ^ fq) & run;

  // Level in the high input half follows the rising-edge index
  p_level_hi_r1: assert property (@(negedge clk_in) disable iff (rst)
    run |-> (clk_out == (hp < span.high)));
  // Level in the low input half follows the falling-edge index
  p_level_lo_r2: assert property (@(posedge clk_in) disable iff (rst)
    run |-> (clk_out == (hn < span.high)));
  // The two edge domains stay one half-period apart
  p_edge_lock_r2: assert property (@(posedge clk_in) disable iff (rst)
    run |-> (hn == step_mod(hp, span.period, 1'b0)));
  p_cfg_hold_r6: assert property (@(posedge clk_in) disable iff (rst)
    run |-> $stable(span));
endmodule

// File: tb/tb_halfstep_clkdiv.sv
module tb_halfstep_clkdiv;
  import hdiv_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CODE_W-1:0] ratio_code = '0;
  logic              prediv_en = 1'b0;
  logic              clk_out;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  halfstep_clkdiv dut (
    .clk_in(clk), .rst(rst), .ratio_code(ratio_code),
    .prediv_en(prediv_en), .clk_out(clk_out)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reset with a code, release, compare 3 periods of half-period levels.
  task automatic run_pattern(input logic [CODE_W-1:0] code, input logic pre,
                             input int ne, input string req, input int change_at);
    int mism = 0;
    int bad_k = 0;
    int bad_v = 0;
    logic expv;
    rst = 1'b1; ratio_code = code; prediv_en = pre;
    repeat (3) begin @(posedge clk); #3; end
    check(clk_out == 1'b0, "R7", "level during reset", clk_out, 0);
    rst = 1'b0;
    for (int k = 0; k < 3*ne; k++) begin
      if (k % 2 == 0) @(posedge clk); else @(negedge clk);
      #1;
      expv = (k % ne) < ((ne + 1) / 2);
      if (k == 0) check(clk_out == 1'b1, "R3", "first rising edge level", clk_out, 1);
      if (clk_out !== expv && mism == 0) begin bad_k = k; bad_v = clk_out; end
      if (clk_out !== expv) mism++;
      if (k == change_at) begin ratio_code = CODE_W'(11); prediv_en = ~pre; end
    end
    if (mism != 0)
      $display("  first mismatch code=%0d pre=%0b at half-period %0d", code, pre, bad_k);
    check(mism == 0, req, $sformatf("pattern code=%0d pre=%0b", code, pre),
          bad_v, int'(!bad_v[0]));
  endtask

  task automatic reset_midrun();
    int highs = 0;
    run_pattern(CODE_W'(16), 1'b0, 16, "R1", -1);
    rst = 1'b1;
    @(posedge clk); #1;
    for (int k = 0; k < 8; k++) begin
      if (clk_out) highs++;
      if (k % 2 == 0) @(negedge clk); else @(posedge clk);
      #1;
    end
    check(highs == 0, "R7", "high samples after mid-run reset", highs, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    run_pattern(CODE_W'(4),  1'b0, 4,  "R1", -1);   // ratio 2
    run_pattern(CODE_W'(14), 1'b0, 14, "R1", -1);   // ratio 7, odd integer
    run_pattern(CODE_W'(32), 1'b0, 32, "R1", -1);   // ratio 16
    run_pattern(CODE_W'(3),  1'b0, 3,  "R2", -1);   // ratio 1.5
    run_pattern(CODE_W'(9),  1'b0, 9,  "R2", -1);   // ratio 4.5
    run_pattern(CODE_W'(15), 1'b0, 15, "R2", -1);   // ratio 7.5
    run_pattern(CODE_W'(9),  1'b1, 18, "R4", -1);
    run_pattern(CODE_W'(32), 1'b1, 64, "R4", -1);
    run_pattern(CODE_W'(2),  1'b0, 4,  "R5", -1);
    run_pattern(CODE_W'(17), 1'b0, 4,  "R5", -1);
    run_pattern(CODE_W'(40), 1'b0, 4,  "R5", -1);
    run_pattern(CODE_W'(0),  1'b0, 4,  "R5", -1);
    run_pattern(CODE_W'(6),  1'b0, 6,  "R6", 3);    // code and pre change mid-run
    reset_midrun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule